// File: doc/BRIEF.md
# Key-Protected Independent Watchdog

This block is a standalone watchdog timer. Its countdown runs on a separate slow clock, so a stalled or misclocked main clock cannot hold it off. Software controls it through a small register set on a simple 32-bit memory-mapped bus. Each bus access is one cycle with valid, write, address and data. Read data is registered and can be sampled on the cycle after the read request.

Control goes through 16-bit magic values written to a key register. One value starts the countdown. One value feeds the counter, which reloads it. Two more values open and close write access to the configuration registers. There are three configuration registers: a power-of-two prescaler code, a 12-bit reload value and a 12-bit window value. The window value is stored only. A new prescaler or reload value crosses into the slow clock domain through a toggle handshake, and a status flag for each one stays set until the slow domain has acknowledged it.

When the 12-bit down-counter expires, the block raises a reset request for one slow-clock cycle. The counter then reloads and keeps running. Once started, only a system reset stops it.

Top module: `iwd_top`

## Requirements
- R1: After reset the byte offsets read as follows: prescaler (0x04) reads 0, reload (0x08) reads 0xFFF, window (0x10) reads 0xFFF and status (0x0C) reads 0. The counter stays stopped and `wdg_rst_req` stays low.
- R2: Writing a key whose low 16 bits are 0xCCCC to offset 0x00 starts the counter. The upper 16 bits of a key write are ignored. Each expiry raises `wdg_rst_req` for exactly one `lclk` cycle. The counter then reloads by itself, so successive requests are spaced (reload + 1) × divider `lclk` cycles apart.
- R3: Prescaler code p selects a divider of 4 × 2^p, up to code 6, which divides by 256. Only the low 3 data bits are used. A code above 6 is stored and used as 6.
- R4: Key 0xAAAA reloads a running counter and restarts the prescaler. Feeds spaced closer than the timeout prevent any request. After the last feed, the request follows within the timeout plus a few `lclk` cycles of synchronization.
- R5: Key 0x5555 opens write access and key 0x0000 closes it. Access is closed after reset. While access is closed, writes to the prescaler, reload or window registers leave the read-back value unchanged.
- R6: A key value other than 0xAAAA, 0xCCCC, 0x5555 and 0x0000 has no effect. It does not open access and it does not start the counter.
- R7: An accepted prescaler write sets status bit 0, and an accepted reload write sets status bit 1. Each bit clears only after the slow domain has taken the new value.
- R8: A write to the prescaler or the reload register is ignored while that register's own status bit is set.
- R9: Once started, no key or register write stops the counter. Reset requests keep arriving.
- R10: The window register can be written and read back while access is open. Its value does not restrict when a feed is accepted.
- R11: Offset 0x00 and the unmapped offsets 0x14 to 0x1C read as 0.
- R12: A feed key written before the start key has no effect, and no reset request follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset, bus domain |
| bus_valid | input | 1 | Access request, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address; bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after a read |
| lclk | input | 1 | Slow counting clock |
| lrst | input | 1 | Synchronous active-high reset, slow domain |
| wdg_rst_req | output | 1 | One-`lclk`-cycle reset request on expiry |

## Verification
The assertions take two things about the inputs for granted. First, `rst` and `lrst` are raised together and held for several cycles of both clocks, with the bus idle during that time, so that the toggle flops on both sides of each crossing start out equal. Second, the prescaler divides by at least 4, so an expiry can never follow the one just before it. The bench keeps to both assumptions. Every test raises both resets for ten slow cycles and issues bus accesses only once both resets are released. It changes configuration only through the decoded offsets. It never re-writes a register before polling its status bit, except in the test that checks that a busy write is ignored.

// File: rtl/iwd_pkg.sv
package iwd_pkg;
  localparam logic [15:0] KEY_FEED  = 16'hAAAA;
  localparam logic [15:0] KEY_START = 16'hCCCC;
  localparam logic [15:0] KEY_OPEN  = 16'h5555;
  localparam logic [15:0] KEY_SHUT  = 16'h0000;

  // word indices of the register offsets (byte offset / 4)
  localparam int IDX_KEY  = 0;
  localparam int IDX_DIV  = 1;
  localparam int IDX_RLD  = 2;
  localparam int IDX_STAT = 3;
  localparam int IDX_WIN  = 4;

  typedef enum logic [2:0] {
    KC_NONE, KC_FEED, KC_START, KC_OPEN, KC_SHUT
  } key_cmd_e;

  function automatic key_cmd_e decode_key(input logic [15:0] k);
    case (k)
      KEY_FEED:  return KC_FEED;
      KEY_START: return KC_START;
      KEY_OPEN:  return KC_OPEN;
      KEY_SHUT:  return KC_SHUT;
      default:   return KC_NONE;
    endcase
  endfunction
endpackage

// File: rtl/iwd_hs_sync.sv
// Toggle handshake carrying one configuration word from the bus domain
// into the slow domain; busy holds until the slow side acknowledges.
module iwd_hs_sync #(
  parameter int          W       = 12,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_data,
  output logic [W-1:0] src_data,
  output logic         busy,
  input  logic         lclk,
  input  logic         lrst,
  output logic [W-1:0] dst_data
);
  logic         req_t;
  logic [1:0]   ack_sync;
  logic [W-1:0] data_q;
  logic [1:0]   req_sync;
  logic         ack_t;
  logic [W-1:0] dst_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_t    <= 1'b0;
      ack_sync <= '0;
      data_q   <= RST_VAL;
    end else begin
      ack_sync <= {ack_sync[0], ack_t};
      if (load && !busy) begin
        data_q <= load_data;
        req_t  <= ~req_t;
      end
    end
  end

  assign busy     = req_t ^ ack_sync[1];
  assign src_data = data_q;

  always_ff @(posedge lclk) begin
    if (lrst) begin
      req_sync <= '0;
      ack_t    <= 1'b0;
      dst_q    <= RST_VAL;
    end else begin
      req_sync <= {req_sync[0], req_t};
      if (req_sync[1] != ack_t) begin
        dst_q <= data_q;
        ack_t <= req_sync[1];
      end
    end
  end

  assign dst_data = dst_q;

  // the word seen by the slow side must not move while it is in flight
  assert_data_hold_R8: assert property (@(posedge clk) disable iff (rst)
    $past(busy) |-> $stable(data_q));
endmodule

// File: rtl/iwd_pulse_sync.sv
// Single-cycle event from the bus domain to the slow domain via a toggle.
module iwd_pulse_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pulse_in,
  input  logic lclk,
  input  logic lrst,
  output logic pulse_out
);
  logic              tog_q;
  logic [STAGES:0]   sync_q;
  logic              out_q;

  always_ff @(posedge clk) begin
    if (rst)           tog_q <= 1'b0;
    else if (pulse_in) tog_q <= ~tog_q;
  end

  always_ff @(posedge lclk) begin
    if (lrst) begin
      sync_q <= '0;
      out_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-1:0], tog_q};
      out_q  <= sync_q[STAGES-1] ^ sync_q[STAGES];
    end
  end

  assign pulse_out = out_q;
endmodule

// File: rtl/iwd_regs.sv
// Bus-side register set: key decode, write lock, window storage, read mux.
module iwd_regs
  import iwd_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 32,
  parameter int PRE_MAX = 6,
  parameter int PRE_W   = 3,
  parameter int RLD_W   = 12,
  parameter int WIN_W   = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              div_load,
  output logic [PRE_W-1:0]  div_wdata,
  input  logic [PRE_W-1:0]  div_src,
  input  logic              div_busy,
  output logic              rld_load,
  output logic [RLD_W-1:0]  rld_wdata,
  input  logic [RLD_W-1:0]  rld_src,
  input  logic              rld_busy,
  output logic              start_pulse,
  output logic              feed_pulse
);
  localparam int SEL_W = ADDR_W - 2;

  logic [SEL_W-1:0] sel;
  logic             wr_en;
  logic             rd_en;
  key_cmd_e         cmd;
  logic             open_q;
  logic [WIN_W-1:0] win_q;
  logic [PRE_W-1:0] pre_raw;
  logic             unused_bits;

  assign sel     = bus_addr[ADDR_W-1:2];
  assign wr_en   = bus_valid && bus_write;
  assign rd_en   = bus_valid && !bus_write;
  assign cmd     = decode_key(bus_wdata[15:0]);
  assign pre_raw = bus_wdata[PRE_W-1:0];
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[DATA_W-1:16]};

  assign div_wdata = (pre_raw > PRE_W'(PRE_MAX)) ? PRE_W'(PRE_MAX) : pre_raw;
  assign rld_wdata = bus_wdata[RLD_W-1:0];
  assign div_load  = wr_en && (sel == SEL_W'(IDX_DIV)) && open_q && !div_busy;
  assign rld_load  = wr_en && (sel == SEL_W'(IDX_RLD)) && open_q && !rld_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q      <= 1'b0;
      win_q       <= '1;
      start_pulse <= 1'b0;
      feed_pulse  <= 1'b0;
    end else begin
      start_pulse <= 1'b0;
      feed_pulse  <= 1'b0;
      if (wr_en && sel == SEL_W'(IDX_KEY)) begin
        case (cmd)
          KC_OPEN:  open_q      <= 1'b1;
          KC_SHUT:  open_q      <= 1'b0;
          KC_START: start_pulse <= 1'b1;
          KC_FEED:  feed_pulse  <= 1'b1;
          default:  ;
        endcase
      end
      if (wr_en && sel == SEL_W'(IDX_WIN) && open_q)
        win_q <= bus_wdata[WIN_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (rd_en) begin
      case (sel)
        SEL_W'(IDX_DIV):  bus_rdata <= DATA_W'(div_src);
        SEL_W'(IDX_RLD):  bus_rdata <= DATA_W'(rld_src);
        SEL_W'(IDX_STAT): bus_rdata <= DATA_W'({rld_busy, div_busy});
        SEL_W'(IDX_WIN):  bus_rdata <= DATA_W'(win_q);
        default:          bus_rdata <= '0;
      endcase
    end
  end

  assert_locked_div_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == SEL_W'(IDX_DIV) && !open_q) |=> $stable(div_src));
  assert_locked_rld_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == SEL_W'(IDX_RLD) && !open_q) |=> $stable(rld_src));
  assert_busy_cause_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(rld_busy) |-> $past(wr_en && sel == SEL_W'(IDX_RLD)));
endmodule

// File: rtl/iwd_core.sv
// Slow-domain countdown: power-of-two prescaler and reloading down-counter.
module iwd_core #(
  parameter int PRE_MAX = 6,
  parameter int PRE_W   = 3,
  parameter int RLD_W   = 12
) (
  input  logic             lclk,
  input  logic             lrst,
  input  logic             start_in,
  input  logic             feed_in,
  input  logic [PRE_W-1:0] div_code,
  input  logic [RLD_W-1:0] rld_val,
  output logic             rst_req
);
  localparam int PD_W = PRE_MAX + 2;

  logic [PD_W-1:0]  div_m1;
  logic [PD_W-1:0]  pdiv_q;
  logic [RLD_W-1:0] cnt_q;
  logic             running_q;
  logic             req_q;
  logic             tick;

  assign div_m1 = (PD_W'(4) << div_code) - PD_W'(1);
  assign tick   = (pdiv_q >= div_m1);

  always_ff @(posedge lclk) begin
    if (lrst) begin
      running_q <= 1'b0;
      cnt_q     <= '1;
      pdiv_q    <= '0;
      req_q     <= 1'b0;
    end else begin
      req_q <= 1'b0;
      if (start_in && !running_q) begin
        running_q <= 1'b1;
        cnt_q     <= rld_val;
        pdiv_q    <= '0;
      end else if (feed_in && running_q) begin
        cnt_q  <= rld_val;
        pdiv_q <= '0;
      end else if (running_q) begin
        if (tick) begin
          pdiv_q <= '0;
          if (cnt_q == '0) begin
            req_q <= 1'b1;
            cnt_q <= rld_val;
          end else begin
            cnt_q <= cnt_q - RLD_W'(1);
          end
        end else begin
          pdiv_q <= pdiv_q + PD_W'(1);
        end
      end
    end
  end

  assign rst_req = req_q;

  assert_req_pulse_R2: assert property (@(posedge lclk) disable iff (lrst)
    rst_req |=> !rst_req);
  assert_no_stop_R9: assert property (@(posedge lclk) disable iff (lrst)
    running_q |=> running_q);
  assert_idle_quiet_R12: assert property (@(posedge lclk) disable iff (lrst)
    !running_q |=> !rst_req);
endmodule

// File: rtl/iwd_top.sv
module iwd_top #(
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 32,
  parameter int PRE_MAX = 6,
  parameter int RLD_W   = 12,
  parameter int WIN_W   = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              lclk,
  input  logic              lrst,
  output logic              wdg_rst_req
);
  localparam int PRE_W  = $clog2(PRE_MAX + 1);
  localparam int N_EV   = 2;

  logic             div_load, rld_load, div_busy, rld_busy;
  logic [PRE_W-1:0] div_wdata, div_src, div_dst;
  logic [RLD_W-1:0] rld_wdata, rld_src, rld_dst;
  logic             start_pulse, feed_pulse;
  logic [N_EV-1:0]  ev_bus, ev_slow;

  iwd_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRE_MAX(PRE_MAX),
    .PRE_W(PRE_W), .RLD_W(RLD_W), .WIN_W(WIN_W)
  ) u_regs (
    .clk(clk), .rst(rst),
    .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .div_load(div_load), .div_wdata(div_wdata), .div_src(div_src), .div_busy(div_busy),
    .rld_load(rld_load), .rld_wdata(rld_wdata), .rld_src(rld_src), .rld_busy(rld_busy),
    .start_pulse(start_pulse), .feed_pulse(feed_pulse)
  );

  iwd_hs_sync #(.W(PRE_W), .RST_VAL('0)) u_div_xfer (
    .clk(clk), .rst(rst), .load(div_load), .load_data(div_wdata),
    .src_data(div_src), .busy(div_busy),
    .lclk(lclk), .lrst(lrst), .dst_data(div_dst)
  );

  iwd_hs_sync #(.W(RLD_W), .RST_VAL('1)) u_rld_xfer (
    .clk(clk), .rst(rst), .load(rld_load), .load_data(rld_wdata),
    .src_data(rld_src), .busy(rld_busy),
    .lclk(lclk), .lrst(lrst), .dst_data(rld_dst)
  );

  assign ev_bus = {feed_pulse, start_pulse};

  for (genvar g = 0; g < N_EV; g++) begin : g_ev
    iwd_pulse_sync #(.STAGES(2)) u_ev (
      .clk(clk), .rst(rst), .pulse_in(ev_bus[g]),
      .lclk(lclk), .lrst(lrst), .pulse_out(ev_slow[g])
    );
  end

  iwd_core #(.PRE_MAX(PRE_MAX), .PRE_W(PRE_W), .RLD_W(RLD_W)) u_core (
    .lclk(lclk), .lrst(lrst),
    .start_in(ev_slow[0]), .feed_in(ev_slow[1]),
    .div_code(div_dst), .rld_val(rld_dst),
    .rst_req(wdg_rst_req)
  );
endmodule

// File: tb/tb_iwd_top.sv
`timescale 1ns/1ps
module tb_iwd_top;
  localparam logic [4:0] A_KEY = 5'h00, A_DIV = 5'h04, A_RLD = 5'h08,
                         A_STAT = 5'h0C, A_WIN = 5'h10;

  logic clk = 0, lclk = 0, rst = 1, lrst = 1;
  logic bus_valid = 0, bus_write = 0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic wdg_rst_req;

  int checks = 0, errors = 0;
  int lcount = 0, pulse_n = 0, wide_n = 0;
  int pulse_t [0:7];
  logic prev_hi = 0;
  logic [31:0] rv;

  always #4 clk = ~clk;
  initial begin #3; forever #20 lclk = ~lclk; end

  iwd_top dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .lclk(lclk), .lrst(lrst), .wdg_rst_req(wdg_rst_req)
  );

  always @(posedge lclk) lcount++;
  always @(negedge lclk) begin
    if (lrst) begin
      pulse_n = 0; wide_n = 0; prev_hi = 0;
    end else begin
      if (wdg_rst_req) begin
        if (pulse_n < 8) pulse_t[pulse_n] = lcount;
        pulse_n++;
        if (prev_hi) wide_n++;
      end
      prev_hi = wdg_rst_req;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); bus_valid = 1; bus_write = 0; bus_addr = a;
    @(negedge clk); bus_valid = 0; d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 300; i++) begin
      rd(A_STAT, s);
      if (s[1:0] == 2'b00) break;
    end
  endtask

  task automatic wait_slow(input int n);
    repeat (n) @(negedge lclk);
  endtask

  task automatic wait_pulses(input int n, input int limit);
    for (int i = 0; i < limit && pulse_n < n; i++) @(negedge lclk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; lrst = 1;
    wait_slow(10);
    lrst = 0;
    @(negedge clk); rst = 0;
    @(negedge clk);
  endtask

  task automatic setup(input int code, input int r);
    do_reset();
    wr(A_KEY, 32'h5555);
    wr(A_DIV, code);
    wr(A_RLD, r);
    wait_idle();
  endtask

  // R2 / R3: spacing of free-running expiries
  task automatic measure(input string tag, input int code, input int div, input int r);
    int per;
    per = (r + 1) * div;
    setup(code, r);
    wr(A_KEY, 32'hFFFF_CCCC);
    wait_pulses(3, per * 4 + 100);
    check({tag, " pulses"}, pulse_n >= 3, 1);
    check({tag, " spacing a"}, pulse_t[1] - pulse_t[0], per);
    check({tag, " spacing b"}, pulse_t[2] - pulse_t[1], per);
    check({tag, " one-cycle pulse"}, wide_n, 0);
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int t0, n0;
    // R1 reset state
    do_reset();
    rd(A_DIV, rv);  check("R1 div", rv, 0);
    rd(A_RLD, rv);  check("R1 rld", rv, 32'hFFF);
    rd(A_WIN, rv);  check("R1 win", rv, 32'hFFF);
    rd(A_STAT, rv); check("R1 stat", rv, 0);
    wait_slow(50);  check("R1 no req", pulse_n, 0);

    // R11 key and unmapped offsets read zero
    rd(A_KEY, rv);  check("R11 key", rv, 0);
    rd(5'h14, rv);  check("R11 0x14", rv, 0);
    rd(5'h1C, rv);  check("R11 0x1C", rv, 0);

    // R5 locked writes ignored, open/close
    wr(A_DIV, 3); wr(A_RLD, 32'h100); wr(A_WIN, 32'h10);
    rd(A_DIV, rv); check("R5 locked div", rv, 0);
    rd(A_RLD, rv); check("R5 locked rld", rv, 32'hFFF);
    rd(A_WIN, rv); check("R5 locked win", rv, 32'hFFF);
    wr(A_KEY, 32'h5555); wr(A_DIV, 3); wait_idle();
    rd(A_DIV, rv); check("R5 open div", rv, 3);
    // R10 window read-back
    wr(A_WIN, 32'h123); rd(A_WIN, rv); check("R10 win", rv, 32'h123);
    wr(A_KEY, 32'h0000); wr(A_DIV, 1); wr(A_WIN, 32'h456);
    rd(A_DIV, rv); check("R5 relocked div", rv, 3);
    rd(A_WIN, rv); check("R5 relocked win", rv, 32'h123);

    // R3 saturation of codes above the maximum
    wr(A_KEY, 32'h5555); wr(A_DIV, 7); wait_idle();
    rd(A_DIV, rv); check("R3 sat 7", rv, 6);

    // R7 busy flags, R8 writes during busy ignored
    do_reset();
    wr(A_KEY, 32'h5555);
    wr(A_RLD, 5); wr(A_RLD, 9);
    rd(A_STAT, rv); check("R7 rld busy", rv & 32'h2, 32'h2);
    wait_idle();
    rd(A_STAT, rv); check("R7 rld done", rv, 0);
    rd(A_RLD, rv);  check("R8 rld kept", rv, 5);
    wr(A_DIV, 2); wr(A_DIV, 4);
    rd(A_STAT, rv); check("R7 div busy", rv & 32'h1, 32'h1);
    wait_idle();
    rd(A_STAT, rv); check("R7 div done", rv, 0);
    rd(A_DIV, rv);  check("R8 div kept", rv, 2);
    wr(A_KEY, 32'hCCCC);
    wait_pulses(3, 2000);
    check("R8 period uses kept values", pulse_t[2] - pulse_t[1], 6 * 16);

    // R2 / R3 sweep over every prescaler code
    for (int c = 0; c <= 6; c++) measure("R3 code", c, 4 << c, 2);
    measure("R3 code7 saturates", 7, 256, 2);
    // R2 sweep over reload values
    for (int r = 2; r <= 12; r++) measure("R2 reload", 0, 4, r);
    measure("R2 reload 100", 1, 8, 100);

    // R6 undefined keys ignored
    setup(0, 2);
    wr(A_KEY, 32'h0000);
    wr(A_KEY, 32'h5556); wr(A_DIV, 2); wait_idle();
    rd(A_DIV, rv); check("R6 bad open key", rv, 0);
    wr(A_KEY, 32'h1234); wr(A_KEY, 32'hCCCD);
    wait_slow(100); check("R6 bad start key", pulse_n, 0);
    // R12 feed before start
    wr(A_KEY, 32'hAAAA);
    wait_slow(100); check("R12 early feed", pulse_n, 0);
    wr(A_KEY, 32'hCCCC);
    wait_slow(100); check("R12 start after", pulse_n > 0, 1);
    // R9 cannot be stopped
    n0 = pulse_n;
    wr(A_KEY, 32'h0000); wr(A_KEY, 32'h5555); wr(A_DIV, 0); wr(A_KEY, 32'h1111);
    wait_slow(100); check("R9 still running", pulse_n > n0 + 3, 1);

    // R4 feeding holds off the request; window set to 0 (R10)
    setup(0, 10);
    wr(A_WIN, 0);
    wr(A_KEY, 32'hCCCC);
    for (int i = 0; i < 20; i++) begin
      repeat (100) @(negedge clk);
      wr(A_KEY, 32'hAAAA);
    end
    check("R4 R10 fed no req", pulse_n, 0);
    t0 = lcount;
    wait_pulses(1, 400);
    check("R4 expiry after last feed", (pulse_n >= 1) && (pulse_t[0] - t0 >= 45) && (pulse_t[0] - t0 <= 52), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule